// File: doc/BRIEF.md
# Host Mailbox Data Buffer Channel

This block is one channel of a byte-wide mailbox between an external host and a local slave processor. The host writes a byte into an input buffer and reads a byte from an output buffer or a status byte. The slave reads the input buffer and loads the output buffer through a single local data register, and it owns an 8-bit status register.

The status register has two kinds of bits. Bits 0, 1 and 3 are hardware flags: output-full, input-full and a latched copy of address bit A2. The slave can read these bits but cannot write them. The remaining bits are general flags that the slave writes and the host can read.

On a host write, the value of A2 is captured in the latched-address flag. This lets slave software tell command bytes (A2 = 1) from data bytes (A2 = 0). On a host read, A2 selects the returned byte: the output buffer or the status register.

Top module: `mbx_channel`

## Requirements
- R1: A host write (`hst_wr`) latches `hst_wdata` into the input buffer, whatever the value of `hst_a2`; the slave sees the byte on `slv_rdata` in the next cycle.
- R2: The input-full flag (status bit 1) is 1 in the cycle after a host write.
- R3: A slave data read (`slv_rd`) clears the input-full flag in the next cycle, unless a host write happens in the same cycle.
- R4: A slave data write (`slv_wr`) loads `slv_wdata` into the output buffer and sets the output-full flag (status bit 0) in the next cycle.
- R5: A host read with `hst_a2` = 0 clears the output-full flag in the next cycle, unless a slave data write happens in the same cycle.
- R6: With the default `RD_REG` = 0, `hst_rdata` shows the output buffer while `hst_a2` = 0 and the status register while `hst_a2` = 1, in the same cycle.
- R7: Every host write captures `hst_a2` into status bit 3.
- R8: A slave status write (`slv_st_wr`) updates status bits 2, 4, 5, 6 and 7 from `slv_st_wdata`. Bits 0, 1 and 3 do not change on a slave status write.
- R9: A host read with `hst_a2` = 1 leaves every status bit and both buffers unchanged.
- R10: When a set event and a clear event for the same full flag fall in the same cycle, the flag ends at 1.
- R11: After reset, both buffers and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr | input | 1 | Host write strobe, one cycle per byte |
| hst_rd | input | 1 | Host read strobe, one cycle per byte |
| hst_a2 | input | 1 | Host address bit A2 |
| hst_wdata | input | DATA_W | Host write data |
| hst_rdata | output | DATA_W | Host read data: output buffer or status |
| slv_rd | input | 1 | Slave read of the data register |
| slv_wr | input | 1 | Slave write of the data register |
| slv_wdata | input | DATA_W | Slave write data for the output buffer |
| slv_rdata | output | DATA_W | Input buffer contents |
| slv_st_wr | input | 1 | Slave write of the status register |
| slv_st_wdata | input | 8 | Slave status write data |
| slv_st_rdata | output | 8 | Status register |

## Verification
The bench targets the cycles in which a set event and a clear event for the same flag coincide. If the clear won in such a cycle, a byte would be left in a buffer with its full flag at 0, so the other side would never read it. The bench also writes all ones to the status register and checks that the hardware flag bits keep their values; a design that got this wrong would let software fake a full flag. A third case reads the status byte with A2 = 1 and checks that the output-full flag stays set, so a design that cleared it on any host read would lose the pending byte. The bench also sends host writes with both values of A2 and checks the latched bit each time, so a design that captured A2 only on some writes would mark bytes as the wrong kind.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned ST_W    = 8;
   localparam int unsigned OBF_BIT = 0;
   localparam int unsigned IBF_BIT = 1;
   localparam int unsigned XA2_BIT = 3;
   // bits writable by slave software
   localparam logic [ST_W-1:0] SW_MASK = 8'hF4;
endpackage

// File: rtl/mbx_flag.sv
module mbx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/mbx_hold.sv
module mbx_hold #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= '0;
      else if (load_i) q_o <= d_i;
   end
endmodule

// File: rtl/mbx_status.sv
module mbx_status
   import mbx_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sw_wr_i,
   input  logic [ST_W-1:0] sw_wdata_i,
   input  logic            obf_i,
   input  logic            ibf_i,
   input  logic            xa2_i,
   output logic [ST_W-1:0] status_o
);
   logic [ST_W-1:0] sw_q;
   logic            unused_hw_wbits;

   assign unused_hw_wbits = ^(sw_wdata_i & ~SW_MASK);

   for (genvar i = 0; i < ST_W; i++) begin : g_bit
      if (SW_MASK[i]) begin : g_sw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sw_q[i] <= 1'b0;
            else if (sw_wr_i) sw_q[i] <= sw_wdata_i[i];
         end
      end else begin : g_hw
         assign sw_q[i] = 1'b0;
      end
   end

   always_comb begin
      status_o          = sw_q;
      status_o[OBF_BIT] = obf_i;
      status_o[IBF_BIT] = ibf_i;
      status_o[XA2_BIT] = xa2_i;
   end
endmodule

// File: rtl/mbx_host_rd.sv
module mbx_host_rd
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter bit          RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  logic              a2_i,
   input  logic [DATA_W-1:0] obuf_i,
   input  logic [ST_W-1:0]   status_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      if (a2_i) sel[ST_W-1:0] = status_i;
      else      sel           = obuf_i;
   end

   if (RD_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    rdata_o <= '0;
         else if (rd_i) rdata_o <= sel;
      end
   end else begin : g_comb
      logic unused_seq;
      assign unused_seq = clk ^ rst_n ^ rd_i;
      assign rdata_o    = sel;
   end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter bit          RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_wr,
   input  logic              hst_rd,
   input  logic              hst_a2,
   input  logic [DATA_W-1:0] hst_wdata,
   output logic [DATA_W-1:0] hst_rdata,
   input  logic              slv_rd,
   input  logic              slv_wr,
   input  logic [DATA_W-1:0] slv_wdata,
   output logic [DATA_W-1:0] slv_rdata,
   input  logic              slv_st_wr,
   input  logic [ST_W-1:0]   slv_st_wdata,
   output logic [ST_W-1:0]   slv_st_rdata
);
   if (DATA_W < ST_W) begin : g_bad_width
      $error("mbx_channel: DATA_W must be at least the status width");
   end

   logic [DATA_W-1:0] obuf_q;
   logic              obf_q, ibf_q, xa2_q, obuf_rd;

   assign obuf_rd = hst_rd & ~hst_a2;

   mbx_hold #(.W(DATA_W)) i_ibuf (
      .clk(clk), .rst_n(rst_n), .load_i(hst_wr), .d_i(hst_wdata), .q_o(slv_rdata));

   mbx_hold #(.W(DATA_W)) i_obuf (
      .clk(clk), .rst_n(rst_n), .load_i(slv_wr), .d_i(slv_wdata), .q_o(obuf_q));

   mbx_hold #(.W(1)) i_xa2 (
      .clk(clk), .rst_n(rst_n), .load_i(hst_wr), .d_i(hst_a2), .q_o(xa2_q));

   mbx_flag i_ibf (
      .clk(clk), .rst_n(rst_n), .set_i(hst_wr), .clr_i(slv_rd), .q_o(ibf_q));

   mbx_flag i_obf (
      .clk(clk), .rst_n(rst_n), .set_i(slv_wr), .clr_i(obuf_rd), .q_o(obf_q));

   mbx_status i_status (
      .clk(clk), .rst_n(rst_n), .sw_wr_i(slv_st_wr), .sw_wdata_i(slv_st_wdata),
      .obf_i(obf_q), .ibf_i(ibf_q), .xa2_i(xa2_q), .status_o(slv_st_rdata));

   mbx_host_rd #(.DATA_W(DATA_W), .RD_REG(RD_REG)) i_host_rd (
      .clk(clk), .rst_n(rst_n), .rd_i(hst_rd), .a2_i(hst_a2),
      .obuf_i(obuf_q), .status_i(slv_st_rdata), .rdata_o(hst_rdata));
endmodule

// File: rtl/mbx_channel_chk.sv
module mbx_channel_chk
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hst_wr,
   input logic              hst_rd,
   input logic              hst_a2,
   input logic [DATA_W-1:0] hst_wdata,
   input logic              slv_rd,
   input logic              slv_wr,
   input logic [DATA_W-1:0] slv_rdata,
   input logic              slv_st_wr,
   input logic [ST_W-1:0]   slv_st_rdata
);
   // R1
   ibuf_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hst_wr |=> slv_rdata == $past(hst_wdata));
   // R2
   ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hst_wr |=> slv_st_rdata[IBF_BIT]);
   // R3
   ibf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slv_rd && !hst_wr) |=> !slv_st_rdata[IBF_BIT]);
   // R4
   obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slv_wr |=> slv_st_rdata[OBF_BIT]);
   // R5
   obf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_rd && !hst_a2 && !slv_wr) |=> !slv_st_rdata[OBF_BIT]);
   // R7
   xa2_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hst_wr |=> slv_st_rdata[XA2_BIT] == $past(hst_a2));
   // R9
   status_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_rd && hst_a2 && !hst_wr && !slv_rd && !slv_wr && !slv_st_wr)
      |=> $stable(slv_st_rdata));
endmodule

bind mbx_channel mbx_channel_chk #(.DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_a2(hst_a2),
   .hst_wdata(hst_wdata), .slv_rd(slv_rd), .slv_wr(slv_wr), .slv_rdata(slv_rdata),
   .slv_st_wr(slv_st_wr), .slv_st_rdata(slv_st_rdata));

// File: tb/test_mbx_channel.sv
`timescale 1ns/1ps
module test_mbx_channel;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hst_wr = 0, hst_rd = 0, hst_a2 = 0, slv_rd = 0, slv_wr = 0, slv_st_wr = 0;
   logic [7:0] hst_wdata = 0, slv_wdata = 0, slv_st_wdata = 0;
   logic [7:0] hst_rdata, slv_rdata, slv_st_rdata;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bench model
   logic [7:0] m_ibuf = 0, m_obuf = 0, m_sw = 0;
   logic       m_ibf = 0, m_obf = 0, m_xa2 = 0;

   always #2 clk = ~clk;

   mbx_channel i_mbx_channel (
      .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_a2(hst_a2),
      .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .slv_rd(slv_rd), .slv_wr(slv_wr),
      .slv_wdata(slv_wdata), .slv_rdata(slv_rdata), .slv_st_wr(slv_st_wr),
      .slv_st_wdata(slv_st_wdata), .slv_st_rdata(slv_st_rdata));

   function automatic logic [7:0] exp_status();
      return (m_sw & 8'hF4) | {4'b0, m_xa2, 1'b0, m_ibf, m_obf};
   endfunction

   function automatic logic [7:0] exp_hrd();
      return hst_a2 ? exp_status() : m_obuf;
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk("R1 slave data", slv_rdata, m_ibuf);
      chk("R2 R3 R4 R5 R7 R8 R9 R10 status", slv_st_rdata, exp_status());
      chk("R6 host read", hst_rdata, exp_hrd());
   endtask

   // apply one cycle: drive at negedge, compare before the edge, update model after
   task automatic step(logic hw, logic hr, logic a2, logic [7:0] hd,
                       logic sr, logic sw, logic [7:0] sd, logic stw, logic [7:0] std);
      @(negedge clk);
      hst_wr = hw; hst_rd = hr; hst_a2 = a2; hst_wdata = hd;
      slv_rd = sr; slv_wr = sw; slv_wdata = sd; slv_st_wr = stw; slv_st_wdata = std;
      #1 compare();
      @(posedge clk);
      if (hw) begin m_ibuf = hd; m_xa2 = a2; end
      m_ibf = hw ? 1'b1 : (sr ? 1'b0 : m_ibf);
      m_obf = sw ? 1'b1 : ((hr && !a2) ? 1'b0 : m_obf);
      if (sw)  m_obuf = sd;
      if (stw) m_sw = std & 8'hF4;
   endtask

   task automatic idle();
      step(0, 0, 0, 8'h00, 0, 0, 8'h00, 0, 8'h00);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      #10;
      // R11 reset state
      chk("R11 status", slv_st_rdata, 8'h00);
      chk("R11 input buf", slv_rdata, 8'h00);
      chk("R11 host rd", hst_rdata, 8'h00);
      @(negedge clk); rst_n = 1'b1;

      // R1 R2 R7: host write with A2=1 (command) then A2=0 (data)
      step(1, 0, 1, 8'hA5, 0, 0, 0, 0, 0);
      step(1, 0, 0, 8'h3C, 0, 0, 0, 0, 0);
      idle();
      // R3: slave read clears input-full
      step(0, 0, 0, 0, 1, 0, 0, 0, 0);
      // R4: slave write loads output buffer
      step(0, 0, 0, 0, 0, 1, 8'h77, 0, 0);
      // R9: status read by host, no side effect
      step(0, 1, 1, 0, 0, 0, 0, 0, 0);
      step(0, 1, 1, 0, 0, 0, 0, 0, 0);
      // R5 R6: host reads output buffer
      step(0, 1, 0, 0, 0, 0, 0, 0, 0);
      idle();
      // R8: slave writes all ones to status, hardware bits hold
      step(0, 0, 0, 0, 0, 0, 0, 1, 8'hFF);
      step(0, 0, 0, 0, 0, 0, 0, 1, 8'h0B);
      // R10: set wins on input-full and output-full
      step(1, 0, 0, 8'h12, 1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 1, 8'h34, 0, 0);
      step(0, 1, 0, 0, 0, 1, 8'h56, 0, 0);
      idle();
      chk("R10 ibf kept", {7'b0, slv_st_rdata[1]}, 8'h01);
      chk("R10 obf kept", {7'b0, slv_st_rdata[0]}, 8'h01);

      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         step($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, 1'($urandom),
              8'($urandom), $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
              8'($urandom), $urandom_range(0, 5) == 0, 8'($urandom));
      end
      idle();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule